// File: doc/BRIEF.md
# Device Interrupt Control Register

This block holds the eight-bit control register that governs how a peripheral device controller raises its interrupt request. Firmware writes and reads the register through a single-address port. Four pending-event inputs arrive from the rest of the controller: transfer done, start-of-frame, bus reset and suspend. The block combines these events with the register's enable fields and drives one interrupt pin. The active level of that pin can be programmed, and so can its signalling, either a level that follows the pending condition or a fixed two-clock pulse.

The same register also carries a software reset control. While the device is awake, setting that bit drives an internal reset output. While the device is suspended, a write of 1 to that bit does not set it. Instead it raises a wake-up request at once, and the reset bit latches only when the suspend input drops. The suspend state is an input; the block does not generate it.

Top module: `dev_irq_ctrl`

## Requirements
- R1: After hardware reset the register reads 00h. A write while awake stores all bits except bit 0. The field positions are: bit 7 pin polarity, bit 6 remote wake-up enable, bit 5 suspend-event enable, bit 4 bus-reset-event enable, bit 3 software reset, bit 2 pulse mode, bit 1 global interrupt enable.
- R2: Bit 0 is reserved. It always reads 0, and writing 1 to it has no effect on the readback.
- R3: With bit 7 clear the pin is active-low. With bit 7 set it is active-high. While inactive, the pin drives the inverse of bit 7.
- R4: With bit 2 set, each rising edge of the enabled pending condition makes the pin active for exactly two clock periods, starting one cycle after the edge. A condition that stays high does not produce a second pulse.
- R5: With bit 2 clear, the pin is active for exactly as long as the enabled pending condition holds.
- R6: The pending condition can be true only while bit 1 is set. Transfer-done and start-of-frame events count with no further enable.
- R7: A bus-reset event counts only while bit 4 is set. A suspend event counts only while bit 5 is set.
- R8: A write while awake that sets bit 3 asserts soft_rst on the next cycle. A write that clears bit 3 releases it.
- R9: A write of 1 to bit 3 while suspended raises wake_req on the next cycle and leaves bit 3 and soft_rst at 0. When suspended falls, bit 3 sets and wake_req drops on the following edge.
- R10: A wake-up started by software reset proceeds whether bit 6 is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register readback |
| ev_xfer | input | 1 | Transfer-done event pending |
| ev_sof | input | 1 | Start-of-frame event pending |
| ev_bus_reset | input | 1 | Bus-reset event pending |
| ev_suspend | input | 1 | Suspend event pending |
| suspended | input | 1 | Device is currently suspended |
| irq_pin | output | 1 | Interrupt request pin |
| soft_rst | output | 1 | Internal reset request from bit 3 |
| wake_req | output | 1 | Silent wake-up request |

## Verification
The assertions assume that the event inputs and `suspended` are synchronous to `clk` and stable between edges. They also assume that `suspended` only falls after a wake-up has been requested or when no wake-up is pending. The pulse-length property further assumes that the mode bit is held for the three cycles it examines. The stimulus changes every input only on the falling edge of the clock. It changes the mode bit only while no event is pending, and it toggles `suspended` only around the directed wake-up sequences, so these assumptions hold throughout.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int REG_W  = 8;
  localparam int NSRC   = 4;

  // field positions within the control register
  localparam int B_POL  = 7;
  localparam int B_RWU  = 6;
  localparam int B_IES  = 5;
  localparam int B_IEB  = 4;
  localparam int B_SRST = 3;
  localparam int B_MODE = 2;
  localparam int B_GIE  = 1;
  localparam int B_RSV  = 0;

  // event source slots
  localparam int S_XFER = 0;
  localparam int S_SOF  = 1;
  localparam int S_BRST = 2;
  localparam int S_SUSP = 3;

  // bits that firmware may write
  function automatic logic [REG_W-1:0] writable_mask();
    logic [REG_W-1:0] m;
    m = '1;
    m[B_RSV] = 1'b0;
    return m;
  endfunction

  // per-source enable derived from register fields
  function automatic logic [NSRC-1:0] src_enables(logic [REG_W-1:0] r);
    logic [NSRC-1:0] e;
    e = '1;
    e[S_BRST] = r[B_IEB];
    e[S_SUSP] = r[B_IES];
    return e;
  endfunction

  // physical pin level from logical activity and polarity
  function automatic logic pin_level(logic active, logic pol);
    return active ? pol : ~pol;
  endfunction
endpackage

// File: rtl/dic_ctrl_reg.sv
module dic_ctrl_reg
  import dic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             suspended,
  output logic [REG_W-1:0] ctrl_q,
  output logic             wake_req,
  output logic             wake_done
);
  localparam logic [REG_W-1:0] WMASK    = writable_mask();
  localparam logic [REG_W-1:0] SRST_BIT = REG_W'(1) << B_SRST;

  logic [REG_W-1:0] ctrl_d;
  logic             pend_q;
  logic             wake_arm;

  assign wake_arm  = wr_en & suspended & wr_data[B_SRST];
  assign wake_done = pend_q & ~suspended;
  assign wake_req  = pend_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      if (suspended)
        ctrl_d = (wr_data & WMASK & ~SRST_BIT) | (ctrl_q & SRST_BIT);
      else
        ctrl_d = wr_data & WMASK;
    end
    if (wake_done)
      ctrl_d[B_SRST] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wake_arm)
        pend_q <= 1'b1;
      else if (wake_done)
        pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dic_src_gate.sv
module dic_src_gate #(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0] src_evt,
  input  logic [NSRC-1:0] src_en,
  input  logic            gie,
  output logic            irq_cond
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = src_evt[i] & src_en[i];
  end

  assign irq_cond = gie & (|hit);
endmodule

// File: rtl/dic_irq_gen.sv
module dic_irq_gen #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_cond,
  input  logic pulse_mode,
  output logic cond_rise,
  output logic irq_active
);
  localparam int CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic          cond_q;
  logic [CW-1:0] cnt_q;

  assign cond_rise = irq_cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cond_q <= irq_cond;
      if (cond_rise)
        cnt_q <= LOAD;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign irq_active = pulse_mode ? (cnt_q != '0) : irq_cond;
endmodule

// File: rtl/dev_irq_ctrl.sv
module dev_irq_ctrl
  import dic_pkg::*;
#(
  parameter int PULSE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ev_xfer,
  input  logic       ev_sof,
  input  logic       ev_bus_reset,
  input  logic       ev_suspend,
  input  logic       suspended,
  output logic       irq_pin,
  output logic       soft_rst,
  output logic       wake_req
);
  logic [REG_W-1:0] ctrl;
  logic [NSRC-1:0]  src_evt;
  logic             irq_cond;
  logic             cond_rise;
  logic             irq_active;
  logic             wake_done;

  dic_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .suspended (suspended),
    .ctrl_q    (ctrl),
    .wake_req  (wake_req),
    .wake_done (wake_done)
  );

  always_comb begin
    src_evt         = '0;
    src_evt[S_XFER] = ev_xfer;
    src_evt[S_SOF]  = ev_sof;
    src_evt[S_BRST] = ev_bus_reset;
    src_evt[S_SUSP] = ev_suspend;
  end

  dic_src_gate #(.NSRC(NSRC)) u_gate (
    .src_evt  (src_evt),
    .src_en   (src_enables(ctrl)),
    .gie      (ctrl[B_GIE]),
    .irq_cond (irq_cond)
  );

  dic_irq_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_cond   (irq_cond),
    .pulse_mode (ctrl[B_MODE]),
    .cond_rise  (cond_rise),
    .irq_active (irq_active)
  );

  assign irq_pin  = pin_level(irq_active, ctrl[B_POL]);
  assign soft_rst = ctrl[B_SRST];
  assign rd_data  = ctrl;
endmodule

// File: rtl/dev_irq_ctrl_chk.sv
module dev_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       suspended,
  input logic       irq_pin,
  input logic       soft_rst,
  input logic       wake_req,
  input logic       wake_done,
  input logic       irq_cond,
  input logic       cond_rise,
  input logic       irq_active
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] == 1'b0);

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_active |-> (irq_pin == !rd_data[7]));

  p_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_rise && rd_data[2]) |=> irq_active);

  p_pulse_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2] && $past(rd_data[2]) && $past(rd_data[2], 2)
     && !$past(cond_rise) && !$past(cond_rise, 2)) |-> !irq_active);

  p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[2] |-> (irq_active == irq_cond));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[1] |-> !irq_cond);

  p_srst_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !suspended && !wake_req) |=> (soft_rst == $past(wr_data[3])));

  p_wake_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && suspended && wr_data[3]) |=> wake_req);

  p_no_early_srst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst) |-> !$past(suspended));

  p_wake_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> (soft_rst && !wake_req));
endmodule

bind dev_irq_ctrl dev_irq_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .suspended  (suspended),
  .irq_pin    (irq_pin),
  .soft_rst   (soft_rst),
  .wake_req   (wake_req),
  .wake_done  (wake_done),
  .irq_cond   (irq_cond),
  .cond_rise  (cond_rise),
  .irq_active (irq_active)
);

// File: tb/dev_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dev_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ev_xfer = 1'b0, ev_sof = 1'b0, ev_bus_reset = 1'b0, ev_suspend = 1'b0;
  logic       suspended = 1'b0;
  logic       irq_pin, soft_rst, wake_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dev_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_xfer(ev_xfer), .ev_sof(ev_sof), .ev_bus_reset(ev_bus_reset),
    .ev_suspend(ev_suspend), .suspended(suspended),
    .irq_pin(irq_pin), .soft_rst(soft_rst), .wake_req(wake_req)
  );

  // entry: {register value, events xfer/sof/busrst/susp, expected pin}, level mode
  localparam logic [12:0] VEC [0:11] = '{
    {8'h02, 4'b1000, 1'b0},   // R6 xfer counts, active low
    {8'h82, 4'b1000, 1'b1},   // R3 active high
    {8'h00, 4'b1000, 1'b1},   // R6 no global enable, idle high
    {8'h80, 4'b1000, 1'b0},   // R3 idle low with polarity set
    {8'h02, 4'b0100, 1'b0},   // R6 sof counts
    {8'h02, 4'b0010, 1'b1},   // R7 bus reset masked
    {8'h12, 4'b0010, 1'b0},   // R7 bus reset enabled
    {8'h02, 4'b0001, 1'b1},   // R7 suspend masked
    {8'h22, 4'b0001, 1'b0},   // R7 suspend enabled
    {8'hA2, 4'b0001, 1'b1},   // R3 suspend enabled, active high
    {8'h92, 4'b0000, 1'b0},   // R5 nothing pending, idle low
    {8'h32, 4'b0011, 1'b0}    // R7 both gated sources
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_ev(input logic [3:0] e);
    {ev_xfer, ev_sof, ev_bus_reset, ev_suspend} = e;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R3 idle high with polarity clear
    check("R1 reset value", rd_data, 8'h00);
    check("R3 reset idle pin", {7'b0, irq_pin}, 8'h01);
    check("R8 reset soft_rst", {7'b0, soft_rst}, 8'h00);

    // R1 R2 full write
    write_reg(8'hFF);
    check("R2 reserved bit reads zero", rd_data, 8'hFE);
    check("R8 soft_rst asserted", {7'b0, soft_rst}, 8'h01);
    write_reg(8'h01);
    check("R2 write to reserved ignored", rd_data, 8'h00);
    check("R8 soft_rst released", {7'b0, soft_rst}, 8'h00);
    write_reg(8'h54);
    check("R1 readback of fields", rd_data, 8'h54);

    // level-mode table
    for (int i = 0; i < 12; i++) begin
      set_ev(4'b0000);
      write_reg(VEC[i][12:5]);
      set_ev(VEC[i][4:1]);
      #1;
      check($sformatf("R5 vector %0d pin", i), {7'b0, irq_pin}, {7'b0, VEC[i][0]});
    end
    set_ev(4'b0000);

    // R5 level held over several cycles
    write_reg(8'h02);
    ev_sof = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R5 level held", {7'b0, irq_pin}, 8'h00);
    end
    ev_sof = 1'b0;
    #1;
    check("R5 level drops", {7'b0, irq_pin}, 8'h01);

    // R4 pulse mode, active low
    write_reg(8'h06);
    ev_xfer = 1'b1;
    #1;
    check("R4 no pulse before edge", {7'b0, irq_pin}, 8'h01);
    tick();
    check("R4 pulse cycle 1", {7'b0, irq_pin}, 8'h00);
    tick();
    check("R4 pulse cycle 2", {7'b0, irq_pin}, 8'h00);
    tick();
    check("R4 pulse ended", {7'b0, irq_pin}, 8'h01);
    tick();
    check("R4 held condition no retrigger", {7'b0, irq_pin}, 8'h01);
    ev_xfer = 1'b0;
    tick();
    ev_xfer = 1'b1;
    tick();
    check("R4 second rising edge pulses", {7'b0, irq_pin}, 8'h00);
    tick();
    check("R4 second pulse cycle 2", {7'b0, irq_pin}, 8'h00);
    tick();
    check("R4 second pulse ended", {7'b0, irq_pin}, 8'h01);
    ev_xfer = 1'b0;
    tick();

    // R4 R3 pulse active high
    write_reg(8'h86);
    ev_sof = 1'b1;
    tick();
    check("R3 R4 high pulse", {7'b0, irq_pin}, 8'h01);
    tick();
    tick();
    check("R3 R4 high pulse ended", {7'b0, irq_pin}, 8'h00);
    ev_sof = 1'b0;
    tick();

    // R9 R10 silent wake, remote wake-up enable clear
    write_reg(8'h00);
    suspended = 1'b1;
    tick();
    write_reg(8'h08);
    check("R9 wake_req raised", {7'b0, wake_req}, 8'h01);
    check("R9 soft_rst held off", {7'b0, soft_rst}, 8'h00);
    check("R10 bit3 not yet set", rd_data, 8'h00);
    tick();
    tick();
    check("R9 wake pending while suspended", {7'b0, wake_req}, 8'h01);
    suspended = 1'b0;
    #1;
    check("R9 no reset before edge", {7'b0, soft_rst}, 8'h00);
    tick();
    check("R9 soft_rst after resume", {7'b0, soft_rst}, 8'h01);
    check("R9 wake_req cleared", {7'b0, wake_req}, 8'h00);
    check("R9 bit3 latched", rd_data, 8'h08);

    // R10 with remote wake-up enable set, R9 suspended write of 0 does not wake
    write_reg(8'h00);
    suspended = 1'b1;
    write_reg(8'h40);
    check("R9 zero write no wake", {7'b0, wake_req}, 8'h00);
    check("R9 suspended write readback", rd_data, 8'h40);
    write_reg(8'h48);
    check("R10 wake with enable set", {7'b0, wake_req}, 8'h01);
    suspended = 1'b0;
    tick();
    check("R10 reset after resume", rd_data, 8'h48);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule